// File: doc/BRIEF.md
# Scatter-Gather Memory-Write Request Generator

This block moves a stream of 32-bit data words into host memory that is scattered over several physical segments. Software loads a list of segments, each given as a 64-bit physical byte address and a byte length, by writing them into the engine one at a time. The engine keeps them in a small queue and takes them in the order they were written. For each segment it emits a series of PCIe memory-write requests on a ready/valid output stream. Each request is a few header words followed by its payload words, and the payload is taken straight from the data input stream.

For each request the engine computes the size and the header form from the current address. Requests are capped at a parameterised maximum payload and never cross a 4 KB page. A request whose target lies below 4 GB carries a 3-word header with a 32-bit address. A request at or above 4 GB carries a 4-word header with the full address. Because the choice is made for every request, a single segment that straddles the 4 GB line produces both forms. When the last request of a segment has been sent and no further segment is waiting, the engine pulses an interrupt request.

Top module: `sgdma_wr_engine`

## Requirements
- R1: After reset, `tlp_valid`, `src_ready`, `irq` and `desc_err` are all low.
- R2: A request whose start address has bits 63:32 all zero uses a 3-word header: word 0 has 0x40 in bits 31:24 and the length in words in bits 9:0, with all other bits zero; word 1 carries the byte enables; word 2 is address bits 31:2 above two zero bits.
- R3: A request whose start address has any of bits 63:32 set uses a 4-word header: word 0 has 0x60 in bits 31:24 and the length in bits 9:0; word 1 carries the byte enables; word 2 is address bits 63:32; word 3 is address bits 31:2 above two zero bits.
- R4: The header form is chosen again for every request, so a 4-word header never carries an all-zero upper address word, and a segment that crosses 4 GB switches form at the crossing.
- R5: A request carries at least one word and at most `MAX_PAYLOAD_BYTES`/4 words. A segment is cut into the largest requests that respect this limit and R6.
- R6: No request spans a 4 KB address boundary.
- R7: Header word 1 holds the first byte enable in bits 3:0 (always 0xF) and the last byte enable in bits 7:4 (0xF, or 0x0 for a one-word request). All its other bits are zero.
- R8: Segments are served in the order they were loaded. Payload words leave in the order they arrived. `tlp_sop` marks header word 0 and `tlp_eop` marks the last payload word of each request.
- R9: `irq` is a single-cycle pulse raised once the last request of a segment has been sent while no further descriptor is queued.
- R10: The queue holds `DESC_DEPTH` entries. A descriptor written while it is full is dropped, and `desc_err` pulses for one cycle.
- R11: A descriptor with a zero length, a length that is not a multiple of 4, or an address that is not word-aligned is dropped, and `desc_err` pulses.
- R12: While `tlp_valid` is high and `tlp_ready` is low, the output word, `tlp_sop` and `tlp_eop` hold and `tlp_valid` stays high. `src_ready` is high only during payload transfer and only while `tlp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_wr_valid | input | 1 | Load one descriptor this cycle |
| desc_wr_addr | input | 64 | Segment start byte address |
| desc_wr_len | input | LEN_W | Segment length in bytes |
| desc_err | output | 1 | Pulse: descriptor dropped (queue full or malformed) |
| src_valid | input | 1 | Payload word available |
| src_data | input | 32 | Payload word |
| src_ready | output | 1 | Payload word taken this cycle when high with `src_valid` |
| tlp_valid | output | 1 | Output word valid |
| tlp_data | output | 32 | Header or payload word |
| tlp_sop | output | 1 | First header word of a request |
| tlp_eop | output | 1 | Last payload word of a request |
| tlp_ready | input | 1 | Downstream accepts the output word |
| irq | output | 1 | Pulse: all loaded segments have been filled |

## Verification
The bench builds the engine with `MAX_PAYLOAD_BYTES` left at 128 and `LEN_W` at 16. With these values a 200-byte segment splits into one full request and one short request, and a segment near the end of a page is cut by the 4 KB rule rather than the size cap. `DESC_DEPTH` is reduced to 4, so six back-to-back loads against a stalled output overflow the queue after a handful of cycles: one descriptor is held by the engine, four sit in the queue and the sixth is dropped. A segment starting eight bytes below 4 GB checks that the header form changes from one request to the next, and random stalls on both streams exercise the hold rules.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR0,
        ST_HDR1,
        ST_HDR2,
        ST_HDR3,
        ST_PAY
    } eng_st_e;

    // request header type codes
    localparam logic [7:0] FT_WR32 = 8'h40;
    localparam logic [7:0] FT_WR64 = 8'h60;

    localparam logic [3:0] BE_ALL  = 4'hF;
    localparam logic [3:0] BE_NONE = 4'h0;

endpackage

// File: rtl/sgdma_desc_fifo.sv
module sgdma_desc_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             do_push, do_pop;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[q.rp];

    always_comb begin
        d = q;
        if (do_push) d.wp = (q.wp == LAST_PTR) ? '0 : q.wp + 1'b1;
        if (do_pop)  d.rp = (q.rp == LAST_PTR) ? '0 : q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

endmodule

// File: rtl/sgdma_req_split.sv
module sgdma_req_split #(
    parameter int LEN_W  = 16,
    parameter int MAX_DW = 32
) (
    input  logic [11:2]      addr_lo,
    input  logic [LEN_W-3:0] rem_dw,
    output logic [LEN_W-1:0] req_dw
);
    logic [LEN_W-1:0] to_page, rem_x, cap;

    always_comb begin
        to_page = LEN_W'(11'd1024 - {1'b0, addr_lo});
        rem_x   = {2'b00, rem_dw};
        cap     = LEN_W'(MAX_DW);
        req_dw  = rem_x;
        if (cap < req_dw)     req_dw = cap;
        if (to_page < req_dw) req_dw = to_page;
    end

endmodule

// File: rtl/sgdma_wr_engine.sv
module sgdma_wr_engine
    import sgdma_pkg::*;
#(
    parameter int LEN_W             = 16,
    parameter int MAX_PAYLOAD_BYTES = 128,
    parameter int DESC_DEPTH        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_wr_valid,
    input  logic [63:0]      desc_wr_addr,
    input  logic [LEN_W-1:0] desc_wr_len,
    output logic             desc_err,
    input  logic             src_valid,
    input  logic [31:0]      src_data,
    output logic             src_ready,
    output logic             tlp_valid,
    output logic [31:0]      tlp_data,
    output logic             tlp_sop,
    output logic             tlp_eop,
    input  logic             tlp_ready,
    output logic             irq
);
    localparam int MAX_DW = MAX_PAYLOAD_BYTES / 4;
    localparam int DESC_W = 64 + LEN_W;

    typedef struct packed {
        eng_st_e          st;
        logic [63:0]      addr;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] left;
        logic             irq;
        logic             err;
    } eng_t;

    eng_t q, d;

    logic              desc_ok, q_empty, q_full, q_pop;
    logic [DESC_W-1:0] q_rdata;
    logic [LEN_W-1:0]  req_dw;
    logic              wide;
    logic [3:0]        last_be;

    assign desc_ok = (desc_wr_addr[1:0] == 2'b00) && (desc_wr_len[1:0] == 2'b00)
                   && (desc_wr_len != '0);
    assign q_pop   = (q.st == ST_IDLE) && !q_empty;

    sgdma_desc_fifo #(.DEPTH(DESC_DEPTH), .WIDTH(DESC_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (desc_wr_valid && desc_ok),
        .wdata ({desc_wr_addr, desc_wr_len}),
        .pop   (q_pop),
        .rdata (q_rdata),
        .empty (q_empty),
        .full  (q_full)
    );

    sgdma_req_split #(.LEN_W(LEN_W), .MAX_DW(MAX_DW)) u_split (
        .addr_lo (q.addr[11:2]),
        .rem_dw  (q.rem[LEN_W-1:2]),
        .req_dw  (req_dw)
    );

    assign wide    = |q.addr[63:32];
    assign last_be = (req_dw == LEN_W'(1)) ? BE_NONE : BE_ALL;

    // output word selection
    always_comb begin
        tlp_valid = 1'b0;
        tlp_data  = '0;
        tlp_sop   = 1'b0;
        tlp_eop   = 1'b0;
        src_ready = 1'b0;
        case (q.st)
            ST_HDR0: begin
                tlp_valid = 1'b1;
                tlp_sop   = 1'b1;
                tlp_data  = {wide ? FT_WR64 : FT_WR32, 14'd0, req_dw[9:0]};
            end
            ST_HDR1: begin
                tlp_valid = 1'b1;
                tlp_data  = {24'd0, last_be, BE_ALL};
            end
            ST_HDR2: begin
                tlp_valid = 1'b1;
                tlp_data  = wide ? q.addr[63:32] : {q.addr[31:2], 2'b00};
            end
            ST_HDR3: begin
                tlp_valid = 1'b1;
                tlp_data  = {q.addr[31:2], 2'b00};
            end
            ST_PAY: begin
                tlp_valid = src_valid;
                tlp_data  = src_data;
                tlp_eop   = (q.left == LEN_W'(1));
                src_ready = tlp_ready;
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        d     = q;
        d.irq = 1'b0;
        d.err = desc_wr_valid && (!desc_ok || q_full);
        case (q.st)
            ST_IDLE: if (!q_empty) begin
                d.addr = q_rdata[DESC_W-1:LEN_W];
                d.rem  = q_rdata[LEN_W-1:0];
                d.st   = ST_HDR0;
            end
            ST_HDR0: if (tlp_ready) begin
                d.left = req_dw;
                d.st   = ST_HDR1;
            end
            ST_HDR1: if (tlp_ready) d.st = ST_HDR2;
            ST_HDR2: if (tlp_ready) d.st = wide ? ST_HDR3 : ST_PAY;
            ST_HDR3: if (tlp_ready) d.st = ST_PAY;
            ST_PAY: if (src_valid && tlp_ready) begin
                d.left = q.left - 1'b1;
                if (q.left == LEN_W'(1)) begin
                    d.addr = q.addr + 64'({req_dw, 2'b00});
                    d.rem  = q.rem - {req_dw[LEN_W-3:0], 2'b00};
                    if (d.rem == '0) begin
                        d.st  = ST_IDLE;
                        d.irq = q_empty;
                    end else begin
                        d.st  = ST_HDR0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq      = q.irq;
    assign desc_err = q.err;

endmodule

// File: rtl/sgdma_wr_engine_chk.sv
module sgdma_wr_engine_chk #(
    parameter int MAX_DW = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tlp_valid,
    input logic        tlp_ready,
    input logic [31:0] tlp_data,
    input logic        tlp_sop,
    input logic        tlp_eop,
    input logic        src_ready,
    input logic        irq,
    input logic        desc_err,
    input logic        desc_wr_valid
);
    logic [2:0] idx_q;
    logic       wide_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wide_q <= 1'b0;
        end else if (tlp_valid && tlp_ready) begin
            if (tlp_eop)              idx_q <= '0;
            else if (idx_q != 3'd7)   idx_q <= idx_q + 1'b1;
            if (tlp_sop)              wide_q <= (tlp_data[31:24] == 8'h60);
        end
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_valid && !tlp_ready) |=> tlp_valid); // R12
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_valid && !tlp_ready) |=> ($stable(tlp_data) && $stable(tlp_sop) && $stable(tlp_eop))); // R12
    AST_SRC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> tlp_ready); // R12
    AST_FMT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_valid && tlp_sop) |-> (tlp_data[31:24] == 8'h40 || tlp_data[31:24] == 8'h60)); // R2
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_valid && tlp_sop) |-> (tlp_data[9:0] != 10'd0 && 32'(tlp_data[9:0]) <= MAX_DW)); // R5
    AST_UPPER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_valid && wide_q && idx_q == 3'd2) |-> (tlp_data != 32'd0)); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |-> $past(desc_wr_valid)); // R10

endmodule

bind sgdma_wr_engine sgdma_wr_engine_chk #(.MAX_DW(MAX_PAYLOAD_BYTES / 4)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tlp_valid     (tlp_valid),
    .tlp_ready     (tlp_ready),
    .tlp_data      (tlp_data),
    .tlp_sop       (tlp_sop),
    .tlp_eop       (tlp_eop),
    .src_ready     (src_ready),
    .irq           (irq),
    .desc_err      (desc_err),
    .desc_wr_valid (desc_wr_valid)
);

// File: tb/sim_sgdma_wr_engine.sv
module sim_sgdma_wr_engine;
    localparam int LEN_W = 16;
    localparam int MAXP  = 128;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             desc_wr_valid = 1'b0;
    logic [63:0]      desc_wr_addr = '0;
    logic [LEN_W-1:0] desc_wr_len = '0;
    logic             desc_err;
    logic             src_valid = 1'b0;
    logic [31:0]      src_data = '0;
    logic             src_ready;
    logic             tlp_valid;
    logic [31:0]      tlp_data;
    logic             tlp_sop, tlp_eop;
    logic             tlp_ready = 1'b0;
    logic             irq;

    always #2 clk = ~clk;

    sgdma_wr_engine #(.LEN_W(LEN_W), .MAX_PAYLOAD_BYTES(MAXP), .DESC_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .desc_wr_valid(desc_wr_valid), .desc_wr_addr(desc_wr_addr),
        .desc_wr_len(desc_wr_len), .desc_err(desc_err),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .tlp_valid(tlp_valid), .tlp_data(tlp_data), .tlp_sop(tlp_sop),
        .tlp_eop(tlp_eop), .tlp_ready(tlp_ready), .irq(irq)
    );

    int checks = 0, errors = 0, cyc = 0;
    int irq_cnt = 0, err_cnt = 0, phase_viol = 0;
    int rdy_mode = 0, src_mode = 0, exp_pay = 0;
    logic [31:0] src_cnt = '0;
    logic        src_fire = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [33:0] exp_q[$];
    logic [33:0] got_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor, away from the active edge
    always @(negedge clk) begin
        src_fire = src_valid && src_ready;
        if (tlp_valid && tlp_ready) got_q.push_back({tlp_sop, tlp_eop, tlp_data});
        if (irq) irq_cnt++;
        if (desc_err) err_cnt++;
        if (src_ready && !tlp_ready) phase_viol++;
    end

    // stimulus for both streams and watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=%0d expected<150000", cyc);
            finish_run();
        end
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (src_fire) src_cnt = src_cnt + 1;
        src_fire = 1'b0;
        tlp_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
        if (!(src_valid && !src_ready)) src_valid = (src_mode == 0) ? 1'b1 : lfsr[5];
        src_data = src_cnt;
    end

    // reference model: expected words for one segment
    task automatic model_desc(input logic [63:0] a, input int len);
        logic [63:0] p;
        int r;
        p = a;
        r = len;
        while (r > 0) begin
            int pg;
            int n;
            int ndw;
            bit hi;
            pg = 4096 - int'(p[11:0]);
            n = r;
            if (n > MAXP) n = MAXP;
            if (pg < n) n = pg;
            ndw = n / 4;
            hi = (p[63:32] != 32'd0);
            exp_q.push_back({1'b1, 1'b0, hi ? 8'h60 : 8'h40, 14'd0, 10'(ndw)});
            exp_q.push_back({2'b00, 24'd0, (ndw == 1) ? 4'h0 : 4'hF, 4'hF});
            if (hi) exp_q.push_back({2'b00, p[63:32]});
            exp_q.push_back({2'b00, p[31:2], 2'b00});
            for (int k = 0; k < ndw; k++) begin
                exp_q.push_back({1'b0, (k == ndw - 1), 32'(exp_pay)});
                exp_pay++;
            end
            p = p + 64'(n);
            r = r - n;
        end
    endtask

    task automatic compare(input string req);
        int n;
        check(got_q.size() == exp_q.size(), req, "word count", 64'(got_q.size()), 64'(exp_q.size()));
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++)
            check(got_q[i] == exp_q[i], req, $sformatf("word %0d {sop,eop,data}", i),
                  64'(got_q[i]), 64'(exp_q[i]));
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic write_desc(input logic [63:0] a, input int len);
        desc_wr_valid = 1'b1;
        desc_wr_addr  = a;
        desc_wr_len   = LEN_W'(len);
        @(posedge clk); #1;
        desc_wr_valid = 1'b0;
    endtask

    task automatic wait_irq(input int target, input string req);
        int t;
        t = 0;
        while (irq_cnt < target && t < 4000) begin
            @(posedge clk);
            t++;
        end
        repeat (8) @(posedge clk);
        #1;
        check(irq_cnt == target, req, "interrupt pulses", 64'(irq_cnt), 64'(target));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(tlp_valid == 1'b0, "R1", "tlp_valid in reset", 64'(tlp_valid), 0);
        check(src_ready == 1'b0, "R1", "src_ready in reset", 64'(src_ready), 0);
        check(irq == 1'b0, "R1", "irq in reset", 64'(irq), 0);
        check(desc_err == 1'b0, "R1", "desc_err in reset", 64'(desc_err), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
    endtask

    task automatic t_single(input logic [63:0] a, input int len, input string req);
        int base;
        base = irq_cnt;
        model_desc(a, len);
        write_desc(a, len);
        wait_irq(base + 1, "R9");
        compare(req);
    endtask

    task automatic t_multi();
        int base;
        base = irq_cnt;
        rdy_mode = 1;
        src_mode = 1;
        model_desc(64'h0000_0000_0001_0000, 40);
        model_desc(64'h0000_0002_0000_0FF0, 24);
        model_desc(64'h0000_0000_0000_7000, 12);
        write_desc(64'h0000_0000_0001_0000, 40);
        write_desc(64'h0000_0002_0000_0FF0, 24);
        write_desc(64'h0000_0000_0000_7000, 12);
        wait_irq(base + 1, "R9 single pulse after queue drains");
        compare("R8 order under stalls");
        check(phase_viol == 0, "R12", "src_ready without tlp_ready", 64'(phase_viol), 0);
        rdy_mode = 0;
        src_mode = 0;
        repeat (2) @(posedge clk); #1;
    endtask

    task automatic t_overflow();
        int ebase, ibase;
        logic [31:0] held;
        ebase = err_cnt;
        ibase = irq_cnt;
        rdy_mode = 2;
        repeat (2) @(posedge clk); #1;
        for (int k = 0; k < 6; k++) begin
            if (k < 5) model_desc(64'h0000_0000_0000_8000 + 64'(k * 256), 4);
            write_desc(64'h0000_0000_0000_8000 + 64'(k * 256), 4);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(err_cnt - ebase == 1, "R10", "dropped loads on full queue", 64'(err_cnt - ebase), 1);
        held = tlp_data;
        repeat (4) @(negedge clk);
        check(tlp_valid == 1'b1, "R12", "valid held under stall", 64'(tlp_valid), 1);
        check(tlp_data == held && tlp_sop == 1'b1, "R12", "word held under stall",
              64'(tlp_data), 64'(held));
        @(posedge clk); #1;
        rdy_mode = 1;
        wait_irq(ibase + 1, "R9");
        compare("R10 five kept in order");
        rdy_mode = 0;
        repeat (2) @(posedge clk); #1;
    endtask

    task automatic t_bad();
        int ebase, ibase;
        ebase = err_cnt;
        ibase = irq_cnt;
        write_desc(64'h0000_0000_0000_4000, 0);
        write_desc(64'h0000_0000_0000_1002, 8);
        write_desc(64'h0000_0000_0000_4000, 6);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(err_cnt - ebase == 3, "R11", "malformed loads flagged", 64'(err_cnt - ebase), 3);
        check(got_q.size() == 0, "R11", "words emitted for malformed loads", 64'(got_q.size()), 0);
        @(posedge clk); #1;
        model_desc(64'h0000_0000_0000_5000, 8);
        write_desc(64'h0000_0000_0000_5000, 8);
        wait_irq(ibase + 1, "R9");
        compare("R11 only the valid load served");
    endtask

    initial begin
        t_reset();
        t_single(64'h0000_0000_0000_1000, 64, "R2 low address");
        t_single(64'h0000_0001_0000_0100, 200, "R3 R5 high address split");
        t_single(64'h0000_0000_0000_3FF0, 48, "R6 page boundary");
        t_single(64'h0000_0000_FFFF_FFF8, 16, "R4 crossing 4 GB");
        t_single(64'h0000_0000_0000_2000, 4, "R7 one-word request");
        t_multi();
        t_overflow();
        t_bad();
        check(phase_viol == 0, "R12", "src_ready phase over run", 64'(phase_viol), 0);
        finish_run();
    end

endmodule